// File: doc/BRIEF.md
# Split-Transaction Dual-Bus Arbiter

This block decides who owns a shared system bus that is built from two resources granted on their own: an address path and a data path. Bus masters (cache controllers on the processor side and a DMA engine) post requests tagged with a transaction kind. Memory slaves post requests to send read data back. The kind of a request decides which resources it needs. A read request or an invalidation broadcast needs only the address path. A write needs both paths in one tenure and is never split. A memory reply needs only the data path. Because the two paths are granted on their own, a read address can go out while an earlier reply is still moving data.

An address tenure always lasts one cycle. A data tenure lasts a number of beats set by an input and captured when the grant is given. The choice of the next owner is made while the current tenure runs, so a data path that ends its last beat in one cycle can carry the next owner's first beat in the following cycle. Each requester group takes turns in round-robin order. A write that has waited too long stops replies from taking the data path, so writes cannot be starved.

Grants are registered one-cycle pulses. A requester holds its request until it sees its grant. The arbiter ignores a request during the cycle in which that requester's grant is high.

Top module: `split_bus_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every grant output and both busy outputs are low.
- R2: A master request of kind 2'b00 (read) or 2'b01 (invalidate) receives an address-only grant. This is a one-cycle pulse on its `m_gnt_a` bit, with its `m_gnt_d` bit low, in the cycle after the request is sampled, unless a both-path grant wins that cycle.
- R3: A slave request receives a data-only grant on `s_gnt_d`. The data path then reads busy from the grant cycle for as many cycles as the captured beat count, and `dbus_last` is high only in the final one of those cycles.
- R4: A master request of kind 2'b10 (write) or 2'b11 (DMA write) receives `m_gnt_a` and `m_gnt_d` for the same master in the same cycle. It is granted only when the data path is free for the next cycle.
- R5: The address path can be granted to one transaction while the data path is still busy with a different transaction.
- R6: A new data grant can appear in the cycle right after the last beat of the previous tenure, and never while a tenure has more than one beat left.
- R7: The beat count is captured on the edge that issues the data grant. A value of 0 acts as 1. Changing `line_beats` during a tenure does not change that tenure's length.
- R8: Within each group (address-only masters, both-path masters, replying slaves) the winner is the first requester above the group's last winner, in cyclic order. After reset the last winner is the highest index.
- R9: At most one address grant and at most one data grant are high in any cycle.
- R10: Replies win the data path over writes until the pending write has waited STARVE_LIM cycles. From then on no reply is granted, and the write takes the data path when it next becomes free.
- R11: A requester whose grant is high in a cycle is not granted again in the next cycle, even if its request is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| m_req | input | N_MST | Request per master, held until granted |
| m_kind | input | 2*N_MST | Transaction kind per master, two bits each |
| m_gnt_a | output | N_MST | Address-path grant pulse per master |
| m_gnt_d | output | N_MST | Data-path grant pulse per master (writes) |
| s_req | input | N_SLV | Reply request per memory slave |
| s_gnt_d | output | N_SLV | Data-path grant pulse per slave |
| line_beats | input | BEAT_W | Beats in a data tenure, 0 acts as 1 |
| abus_busy | output | 1 | Address path in use this cycle |
| dbus_busy | output | 1 | Data path in use this cycle |
| dbus_last | output | 1 | Final beat of the current data tenure |

## Verification
A wrong beat counter shows on `dbus_busy` and `dbus_last` within one tenure. It also shows as a data grant that lands on top of a tenure that is still running, or as a gap after one. A stale round-robin pointer shows on the very next contended grant, as the wrong index. A broken age counter shows as writes that wait without bound while replies keep taking the data path, or as replies that are held back although no write is waiting. Directed sequences fix the exact cycle of each of these effects. A long random run watches every cycle for double grants, grants that do not match the request's kind, and requests that are never served.

// File: rtl/split_bus_pkg.sv
package split_bus_pkg;

   typedef enum logic [1:0] {
      KIND_READ    = 2'b00,
      KIND_INVAL   = 2'b01,
      KIND_WRITE   = 2'b10,
      KIND_DMA_WR  = 2'b11
   } bus_kind_e;

   // True for kinds that hold both paths in one tenure.
   function automatic logic kind_needs_data(input logic [1:0] k);
      logic r;
      case (bus_kind_e'(k))
         KIND_WRITE, KIND_DMA_WR: r = 1'b1;
         default:                 r = 1'b0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   input  logic         take,
   output logic [N-1:0] gnt
);
   localparam int IW = (N > 1) ? $clog2(N) : 1;

   initial begin
      assert (N >= 1) else $error("rr_pick: N must be at least 1");
   end

   logic [IW-1:0] last_q;

   always_comb begin
      int idx;
      gnt = '0;
      for (int off = 1; off <= N; off++) begin
         idx = (int'(last_q) + off) % N;
         if (req[idx] && gnt == '0) gnt[idx] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q <= IW'(N - 1);
      end else if (take) begin
         for (int i = 0; i < N; i++) begin
            if (gnt[i]) last_q <= IW'(i);
         end
      end
   end

   // R8
   rr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> ($countones(gnt) == 1 && (gnt & ~req) == '0));

endmodule

// File: rtl/data_tenure.sv
module data_tenure #(
   parameter int BEAT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [BEAT_W-1:0] beats,
   output logic              busy,
   output logic              last,
   output logic              free_next
);
   initial begin
      assert (BEAT_W >= 1 && BEAT_W <= 16) else $error("data_tenure: BEAT_W out of range");
   end

   logic [BEAT_W-1:0] left_q;
   logic [BEAT_W-1:0] load_val;

   assign load_val  = (beats == '0) ? BEAT_W'(1) : beats;
   assign busy      = (left_q != '0);
   assign last      = (left_q == BEAT_W'(1));
   assign free_next = (left_q <= BEAT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           left_q <= '0;
      else if (start)       left_q <= load_val;
      else if (left_q != 0) left_q <= left_q - BEAT_W'(1);
   end

   // R3
   tenure_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
   // R6
   tenure_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last && !start) |=> !busy);
   // R6
   no_midway_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last) |-> !start);

endmodule

// File: rtl/wait_age.sv
module wait_age #(
   parameter int LIM = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pending,
   input  logic served,
   output logic starve
);
   localparam int CW = $clog2(LIM + 1);

   initial begin
      assert (LIM >= 1) else $error("wait_age: LIM must be at least 1");
   end

   logic [CW-1:0] age_q;

   assign starve = (age_q >= CW'(LIM));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 age_q <= '0;
      else if (!pending || served) age_q <= '0;
      else if (age_q < CW'(LIM))  age_q <= age_q + CW'(1);
   end

   // R10
   starve_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (starve && pending && !served) |=> starve);

endmodule

// File: rtl/split_bus_arbiter.sv
module split_bus_arbiter
   import split_bus_pkg::*;
#(
   parameter int N_MST      = 4,
   parameter int N_SLV      = 2,
   parameter int BEAT_W     = 4,
   parameter int STARVE_LIM = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_MST-1:0]     m_req,
   input  logic [2*N_MST-1:0]   m_kind,
   output logic [N_MST-1:0]     m_gnt_a,
   output logic [N_MST-1:0]     m_gnt_d,
   input  logic [N_SLV-1:0]     s_req,
   output logic [N_SLV-1:0]     s_gnt_d,
   input  logic [BEAT_W-1:0]    line_beats,
   output logic                 abus_busy,
   output logic                 dbus_busy,
   output logic                 dbus_last
);
   initial begin
      assert (N_MST >= 1) else $error("split_bus_arbiter: N_MST must be at least 1");
      assert (N_SLV >= 1) else $error("split_bus_arbiter: N_SLV must be at least 1");
      assert (STARVE_LIM >= 1) else $error("split_bus_arbiter: STARVE_LIM must be at least 1");
   end

   logic [N_MST-1:0] need_d;
   logic [N_MST-1:0] a_cand, b_cand, a_pick, b_pick;
   logic [N_SLV-1:0] d_cand, s_pick;
   logic             d_free_next, starve;
   logic             a_go, b_go, r_go;

   for (genvar gi = 0; gi < N_MST; gi++) begin : g_kind
      assign need_d[gi] = kind_needs_data(m_kind[2*gi +: 2]);
   end

   // A requester is ignored in the cycle its grant is high.
   assign a_cand = m_req & ~need_d & ~m_gnt_a;
   assign b_cand = m_req &  need_d & ~m_gnt_a;
   assign d_cand = s_req & ~s_gnt_d;

   assign b_go = (|b_cand) && d_free_next && (starve || !(|d_cand));
   assign r_go = (|d_cand) && d_free_next && !b_go && !(starve && |b_cand);
   assign a_go = (|a_cand) && !b_go;

   rr_pick #(.N(N_MST)) u_addr_rr (
      .clk(clk), .rst_n(rst_n), .req(a_cand), .take(a_go), .gnt(a_pick));

   rr_pick #(.N(N_MST)) u_both_rr (
      .clk(clk), .rst_n(rst_n), .req(b_cand), .take(b_go), .gnt(b_pick));

   rr_pick #(.N(N_SLV)) u_reply_rr (
      .clk(clk), .rst_n(rst_n), .req(d_cand), .take(r_go), .gnt(s_pick));

   data_tenure #(.BEAT_W(BEAT_W)) u_dten (
      .clk(clk), .rst_n(rst_n), .start(b_go || r_go), .beats(line_beats),
      .busy(dbus_busy), .last(dbus_last), .free_next(d_free_next));

   wait_age #(.LIM(STARVE_LIM)) u_age (
      .clk(clk), .rst_n(rst_n), .pending(|b_cand), .served(b_go),
      .starve(starve));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_gnt_a <= '0;
         m_gnt_d <= '0;
         s_gnt_d <= '0;
      end else begin
         m_gnt_a <= (a_go ? a_pick : '0) | (b_go ? b_pick : '0);
         m_gnt_d <= b_go ? b_pick : '0;
         s_gnt_d <= r_go ? s_pick : '0;
      end
   end

   assign abus_busy = |m_gnt_a;

   // R9
   addr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(m_gnt_a));
   // R9
   data_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({m_gnt_d, s_gnt_d}));
   // R4
   both_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|m_gnt_d) |-> (m_gnt_d == m_gnt_a));
   // R2
   addr_only_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_gnt_a & ~m_gnt_d & $past(need_d)) == '0);
   // R6
   data_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dbus_busy && !dbus_last) |=> !(|{m_gnt_d, s_gnt_d}));
   // R11
   regrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|m_gnt_a) |=> ((m_gnt_a & $past(m_gnt_a)) == '0));
   // R10
   starve_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (starve && |b_cand) |=> !(|s_gnt_d));

endmodule

// File: tb/split_bus_arbiter_tb_top.sv
module split_bus_arbiter_tb_top;
   localparam int NM = 4;
   localparam int NS = 2;
   localparam int BW = 4;
   localparam int LIM = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NM-1:0] m_req = '0;
   logic [2*NM-1:0] m_kind = '0;
   logic [NM-1:0] m_gnt_a, m_gnt_d;
   logic [NS-1:0] s_req = '0;
   logic [NS-1:0] s_gnt_d;
   logic [BW-1:0] line_beats = '0;
   logic          abus_busy, dbus_busy, dbus_last;

   int checks = 0;
   int fails = 0;
   int cyc = 0;

   always #4 clk = ~clk;

   split_bus_arbiter #(.N_MST(NM), .N_SLV(NS), .BEAT_W(BW), .STARVE_LIM(LIM)) dut_i (
      .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_kind(m_kind),
      .m_gnt_a(m_gnt_a), .m_gnt_d(m_gnt_d), .s_req(s_req), .s_gnt_d(s_gnt_d),
      .line_beats(line_beats), .abus_busy(abus_busy), .dbus_busy(dbus_busy),
      .dbus_last(dbus_last));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic set_kind(input int m, input logic [1:0] k);
      m_kind[2*m +: 2] = k;
   endtask

   function automatic int eff_beats(input logic [BW-1:0] b);
      return (b == '0) ? 1 : int'(b);
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int k, sg;
      int dcnt, prev;
      int wait_m [NM];
      int wait_s [NS];
      logic [BW-1:0] beats_prev;
      void'($urandom(32'd2024));

      // R1 reset
      repeat (3) @(posedge clk);
      #1;
      chk({m_gnt_a, m_gnt_d, s_gnt_d, abus_busy, dbus_busy} == '0, "R1 in reset", 0, 0);
      rst_n = 1'b1;
      step();
      chk({m_gnt_a, m_gnt_d, s_gnt_d, abus_busy, dbus_busy} == '0, "R1 after release", 0, 0);

      // R2 / R11: read from master 1, request held one cycle too long
      set_kind(1, 2'b00); m_req = 4'b0010;
      step();
      chk(m_gnt_a == 4'b0010 && m_gnt_d == 0 && abus_busy, "R2 read grant", m_gnt_a, 4'b0010);
      step();
      chk(m_gnt_a == 4'b0000, "R11 no regrant", m_gnt_a, 0);
      m_req = '0;
      step();
      chk(m_gnt_a == 4'b0000, "R2 pulse ends", m_gnt_a, 0);

      // R3 / R5: reply of 3 beats, read address during it
      line_beats = 4'd3; s_req = 2'b01;
      step();
      chk(s_gnt_d == 2'b01 && dbus_busy && !dbus_last, "R3 reply grant", s_gnt_d, 1);
      s_req = '0; set_kind(2, 2'b01); m_req = 4'b0100;
      step();
      chk(dbus_busy && !dbus_last && s_gnt_d == 0, "R3 beat 2", dbus_last, 0);
      chk(m_gnt_a == 4'b0100 && m_gnt_d == 0, "R5 addr during data", m_gnt_a, 4'b0100);
      m_req = '0;
      step();
      chk(dbus_busy && dbus_last, "R3 last beat", dbus_last, 1);
      step();
      chk(!dbus_busy && !dbus_last, "R3 idle after", dbus_busy, 0);

      // R4: write from master 3
      line_beats = 4'd2; set_kind(3, 2'b10); m_req = 4'b1000;
      step();
      chk(m_gnt_a == 4'b1000 && m_gnt_d == 4'b1000 && dbus_busy && abus_busy,
          "R4 both grants", {m_gnt_a, m_gnt_d}, 8'h88);
      m_req = '0;
      step(); step();

      // R6 / R8: two slaves back to back, slave 1 first
      s_req = 2'b11;
      step();
      chk(s_gnt_d == 2'b10, "R8 slave order", s_gnt_d, 2'b10);
      s_req = 2'b01;
      step();
      chk(dbus_last && s_gnt_d == 0, "R6 last before next", dbus_last, 1);
      step();
      chk(s_gnt_d == 2'b01 && dbus_busy && !dbus_last, "R6 no idle gap", s_gnt_d, 2'b01);
      s_req = '0;
      step(); step();

      // R7: beat count 0 acts as 1
      line_beats = 4'd0; s_req = 2'b01;
      step();
      chk(s_gnt_d == 2'b01 && dbus_busy && dbus_last, "R7 zero beats", dbus_last, 1);
      s_req = '0;
      step();
      chk(!dbus_busy, "R7 zero beats end", dbus_busy, 0);

      // R7: beats captured at grant
      line_beats = 4'd3; s_req = 2'b10;
      step();
      chk(s_gnt_d == 2'b10, "R7 latch grant", s_gnt_d, 2'b10);
      s_req = '0; line_beats = 4'd1;
      step();
      chk(dbus_busy && !dbus_last, "R7 latch beat 2", dbus_last, 0);
      step();
      chk(dbus_busy && dbus_last, "R7 latch beat 3", dbus_last, 1);
      step();
      chk(!dbus_busy, "R7 latch done", dbus_busy, 0);

      // R8 / R9 / R11: four reads at once, last address winner was 2
      for (int m = 0; m < NM; m++) set_kind(m, 2'b00);
      m_req = 4'b1111;
      for (int n = 0; n < NM; n++) begin
         int want;
         want = (3 + n) % NM;
         step();
         chk(m_gnt_a == 4'(1 << want), "R8 address rr order", m_gnt_a, 1 << want);
         chk($countones(m_gnt_a) == 1, "R9 one address grant", m_gnt_a, 0);
         m_req = m_req & ~m_gnt_a;
      end
      step();
      chk(m_gnt_a == 0, "R11 all served once", m_gnt_a, 0);

      // R10: write against continuous replies
      line_beats = 4'd2; s_req = 2'b11;
      repeat (4) step();
      set_kind(0, 2'b11); m_req = 4'b0001;
      k = 0; sg = 0;
      for (int n = 1; n <= 20; n++) begin
         step();
         k = n;
         if (m_gnt_d[0]) break;
         if (|s_gnt_d) sg++;
      end
      chk(k >= 7 && k <= 8, "R10 write waits then wins", k, 7);
      chk(sg >= 2, "R10 replies keep priority", sg, 2);
      chk(m_gnt_a == 4'b0001, "R4 dma write both", m_gnt_a, 1);
      m_req = '0; s_req = '0;
      repeat (4) step();
      chk(!dbus_busy && !abus_busy, "R1 idle before random", dbus_busy, 0);

      // Random phase
      dcnt = 0;
      for (int m = 0; m < NM; m++) wait_m[m] = 0;
      for (int s = 0; s < NS; s++) wait_s[s] = 0;
      beats_prev = line_beats;
      for (int n = 0; n < 3000; n++) begin
         step();
         chk($onehot0(m_gnt_a), "R9 rand addr", m_gnt_a, 0);
         chk($onehot0({m_gnt_d, s_gnt_d}), "R9 rand data", {m_gnt_d, s_gnt_d}, 0);
         for (int m = 0; m < NM; m++) begin
            if (m_gnt_a[m]) begin
               chk(m_req[m] == 1'b1, "R2 rand granted requester", 0, 1);
               chk(m_gnt_d[m] == m_kind[2*m+1], "R4 rand kind match", m_gnt_d[m], m_kind[2*m+1]);
            end
            chk(!(m_gnt_d[m] && !m_gnt_a[m]), "R4 rand pairing", m_gnt_d[m], 0);
         end
         for (int s = 0; s < NS; s++)
            if (s_gnt_d[s]) chk(s_req[s] == 1'b1, "R3 rand granted slave", 0, 1);
         prev = dcnt;
         if (|{m_gnt_d, s_gnt_d}) begin
            chk(prev <= 1, "R6 rand no overlap", prev, 1);
            dcnt = eff_beats(beats_prev);
         end else if (dcnt > 0) begin
            dcnt--;
         end
         chk(dbus_busy == (dcnt != 0), "R3 rand busy", dbus_busy, dcnt != 0);
         chk(dbus_last == (dcnt == 1), "R7 rand last", dbus_last, dcnt == 1);

         for (int m = 0; m < NM; m++) begin
            if (m_gnt_a[m]) begin m_req[m] = 1'b0; wait_m[m] = 0; end
            else if (m_req[m]) wait_m[m]++;
            if (wait_m[m] > 150) begin
               chk(0, "R10 master served", wait_m[m], 150);
               wait_m[m] = 0;
            end
            if (!m_req[m] && ($urandom % 4) == 0) begin
               set_kind(m, 2'($urandom % 4));
               m_req[m] = 1'b1;
            end
         end
         for (int s = 0; s < NS; s++) begin
            if (s_gnt_d[s]) begin s_req[s] = 1'b0; wait_s[s] = 0; end
            else if (s_req[s]) wait_s[s]++;
            if (wait_s[s] > 150) begin
               chk(0, "R10 slave served", wait_s[s], 150);
               wait_s[s] = 0;
            end
            if (!s_req[s] && ($urandom % 3) == 0) s_req[s] = 1'b1;
         end
         if (($urandom % 8) == 0) line_beats = BW'($urandom % 5);
         beats_prev = line_beats;
      end

      m_req = '0; s_req = '0;
      repeat (8) step();
      chk(!dbus_busy && !abus_busy, "R3 drained", dbus_busy, 0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule